// File: doc/BRIEF.md
# SPI EEPROM Slave Command Engine

This block is a serial memory target that behaves like a small byte-addressed EEPROM behind a four-wire SPI link running in mode 0. All logic runs on the system clock. The serial clock, chip select and data-in lines are synchronised and edge-detected, so the serial clock must be several times slower than the system clock. While chip select is low, the first byte is decoded as a command. Depending on the command, an address phase, a data phase or a status readout follows.

A write first needs the write-enable latch to be set. The write then streams data bytes into a 32-byte staging page. When chip select rises cleanly on a byte boundary, a timed programming cycle starts. At the end of that cycle the staged bytes are committed to the array and the latch clears itself. While programming is under way, the only command answered is the status read. Reads stream sequential bytes out of the array for as long as chip select stays low.

Top module: `spi_eeprom_slave`

## Requirements
- R1: SI is sampled on rising SCK, and SO changes after falling SCK. The output enable `so_oe_o` is low whenever chip select is high, and also whenever the current command returns no data.
- R2: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. Status bit 1 shows the latch.
- R3: Opcode 0x05 returns the status byte, most significant bit first. The byte is 6'b0, then the latch, then busy in bit 0. It is sent again after each 8 clocks while chip select stays low.
- R4: Opcode 0x02 is followed by a 16-bit address and then data bytes, all most significant bit first. If chip select rises with SCK low right after bit 0 of a data byte, busy reads 1 for PROG_CYCLES system clocks. After that, the written bytes read back.
- R5: During a write, only the low 5 address bits advance after each byte. The page wraps, so byte 33 overwrites the byte at the start address.
- R6: If chip select rises part way through a data byte, the whole write is discarded. Busy stays 0 and the array is unchanged.
- R7: While busy, every opcode except 0x05 is ignored, and SO stays disabled.
- R8: The write-enable latch clears when a programming cycle ends.
- R9: Opcode 0x02 with the latch clear is ignored. No programming starts, and nothing else is decoded until chip select goes high.
- R10: Opcode 0x03 plus a 16-bit address returns sequential bytes. The full array address increments and wraps from the last byte to 0.
- R11: Address bits at and above ADDR_W are ignored. With the default ADDR_W of 10, address 0xFC40 selects the same byte as 0x0040.
- R12: Unknown opcodes, and opcode 0x01 with its data byte, have no effect. SO stays disabled until chip select goes high.
- R13: After reset, SO is disabled, the latch is 0 and busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from the master, idle low |
| csn_i | input | 1 | Chip select, active low |
| si_i | input | 1 | Serial data in |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for the SO tri-state driver |

## Verification
The bench targets the edges of a write. It sends a write that ends three bits into a data byte; a design that committed anyway would report busy and corrupt the byte. It sends a 34-byte write; a design that carried the increment into the upper address bits would spill the data into the next page instead of overwriting the start of its own page. It also sends a read whose address has the upper bits set, and a read that crosses the end of the array; a design that decoded those bits or stopped at the boundary would return the wrong bytes. Commands sent during programming are checked to leave SO disabled, and the status byte is checked to return to zero once the write-enable latch has cleared itself.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OP, ST_ADDR, ST_WDATA, ST_RDATA, ST_STAT, ST_SKIP
  } st_e;
endpackage

// File: rtl/spi_ee_sync.sv
module spi_ee_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic csn_i,
  input  logic si_i,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic cs_fall_o,
  output logic cs_rise_o,
  output logic cs_act_o,
  output logic sck_lvl_o,
  output logic si_o
);
  // bit2 sck, bit1 csn, bit0 si
  logic [2:0] s1_q, s2_q;
  logic [1:0] s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 3'b010;
      s2_q <= 3'b010;
      s3_q <= 2'b01;
    end else begin
      s1_q <= {sck_i, csn_i, si_i};
      s2_q <= s1_q;
      s3_q <= s2_q[2:1];
    end
  end

  assign sck_rise_o = s2_q[2] & ~s3_q[1];
  assign sck_fall_o = ~s2_q[2] & s3_q[1];
  assign cs_fall_o  = ~s2_q[1] & s3_q[0];
  assign cs_rise_o  = s2_q[1] & ~s3_q[0];
  assign cs_act_o   = ~s2_q[1];
  assign sck_lvl_o  = s2_q[2];
  assign si_o       = s2_q[0];
endmodule

// File: rtl/spi_ee_prog_timer.sv
module spi_ee_prog_timer #(
  parameter int PROG_CYCLES = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(PROG_CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (start_i && !busy_o) cnt_q <= CW'(PROG_CYCLES);
    else if (busy_o)             cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == CW'(1));
endmodule

// File: rtl/spi_ee_store.sv
module spi_ee_store #(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 5
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clr_i,
  input  logic [ADDR_W-PAGE_W-1:0] page_i,
  input  logic                     we_i,
  input  logic [PAGE_W-1:0]        idx_i,
  input  logic [7:0]               wdata_i,
  input  logic                     commit_i,
  input  logic [ADDR_W-1:0]        raddr_i,
  output logic [7:0]               rdata_o
);
  localparam int PAGE  = 1 << PAGE_W;
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0]               stg_q [PAGE];
  logic [PAGE-1:0]          vld_q;
  logic [ADDR_W-PAGE_W-1:0] page_q;
  logic [7:0]               mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    page_q <= '0;
    else if (clr_i) page_q <= page_i;
  end

  for (genvar g = 0; g < PAGE; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stg_q[g] <= '0;
        vld_q[g] <= 1'b0;
      end else if (clr_i) begin
        vld_q[g] <= 1'b0;
      end else if (we_i && idx_i == PAGE_W'(g)) begin
        stg_q[g] <= wdata_i;
        vld_q[g] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (commit_i) begin
      for (int i = 0; i < PAGE; i++) begin
        if (vld_q[i]) mem_q[{page_q, PAGE_W'(i)}] <= stg_q[i];
      end
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave
  import spi_ee_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int PAGE_W      = 5,
  parameter int PROG_CYCLES = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic csn_i,
  input  logic si_i,
  output logic so_o,
  output logic so_oe_o
);
  localparam int HI_W = ADDR_W - 8;

  logic sck_rise, sck_fall, cs_fall, cs_rise, cs_act, sck_lvl, si_s;
  st_e st_q;
  logic [2:0] bit_cnt_q, tx_cnt_q;
  logic [6:0] sh_q;
  logic [7:0] tx_q, rx_byte, rd_data, status;
  logic [HI_W-1:0] addr_hi_q;
  logic addr_second_q, rd_mode_q, wr_ok_q, wel_q, so_q, oe_q;
  logic [PAGE_W-1:0] w_lo_q;
  logic [ADDR_W-1:0] rd_ptr_q, addr_full, rd_addr;
  logic byte_done, prog_start, busy, prog_done, stg_clr, stg_we;

  spi_ee_sync u_sync (
    .clk_i, .rst_ni, .sck_i, .csn_i, .si_i,
    .sck_rise_o(sck_rise), .sck_fall_o(sck_fall), .cs_fall_o(cs_fall),
    .cs_rise_o(cs_rise), .cs_act_o(cs_act), .sck_lvl_o(sck_lvl), .si_o(si_s)
  );

  spi_ee_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk_i, .rst_ni, .start_i(prog_start), .busy_o(busy), .done_o(prog_done)
  );

  spi_ee_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_store (
    .clk_i, .rst_ni,
    .clr_i(stg_clr), .page_i(addr_full[ADDR_W-1:PAGE_W]),
    .we_i(stg_we), .idx_i(w_lo_q), .wdata_i(rx_byte),
    .commit_i(prog_done), .raddr_i(rd_addr), .rdata_o(rd_data)
  );

  assign rx_byte    = {sh_q, si_s};
  assign byte_done  = sck_rise & cs_act & (st_q != ST_IDLE) & (bit_cnt_q == 3'd7);
  assign addr_full  = {addr_hi_q, rx_byte};   // upper address bits dropped
  assign rd_addr    = (st_q == ST_ADDR) ? addr_full : rd_ptr_q;
  assign status     = {6'b0, wel_q, busy};
  assign stg_clr    = byte_done & (st_q == ST_ADDR) & addr_second_q & ~rd_mode_q;
  assign stg_we     = byte_done & (st_q == ST_WDATA);
  // commit only on a clean byte boundary with SCK low
  assign prog_start = cs_rise & (st_q == ST_WDATA) & wr_ok_q & ~sck_lvl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;
      bit_cnt_q <= '0;
      tx_cnt_q <= '0;
      sh_q <= '0;
      tx_q <= '0;
      addr_hi_q <= '0;
      addr_second_q <= 1'b0;
      rd_mode_q <= 1'b0;
      wr_ok_q <= 1'b0;
      wel_q <= 1'b0;
      so_q <= 1'b0;
      oe_q <= 1'b0;
      w_lo_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      if (prog_done) wel_q <= 1'b0;
      if (cs_fall) begin
        st_q <= ST_OP;
        bit_cnt_q <= '0;
        oe_q <= 1'b0;
      end else if (cs_rise || !cs_act) begin
        st_q <= ST_IDLE;
        oe_q <= 1'b0;
      end else begin
        if (sck_rise && st_q != ST_IDLE) begin
          sh_q <= rx_byte[6:0];
          bit_cnt_q <= bit_cnt_q + 1'b1;
          if (st_q == ST_WDATA && bit_cnt_q == 3'd0) wr_ok_q <= 1'b0;
        end
        if (byte_done) begin
          unique case (st_q)
            ST_OP: begin
              if (busy && rx_byte != OP_RDSR) st_q <= ST_SKIP;
              else begin
                unique case (rx_byte)
                  OP_WREN: begin wel_q <= 1'b1; st_q <= ST_SKIP; end
                  OP_WRDI: begin wel_q <= 1'b0; st_q <= ST_SKIP; end
                  OP_RDSR: begin
                    st_q <= ST_STAT;
                    tx_q <= status;
                    tx_cnt_q <= '0;
                    oe_q <= 1'b1;
                  end
                  OP_READ: begin
                    st_q <= ST_ADDR;
                    rd_mode_q <= 1'b1;
                    addr_second_q <= 1'b0;
                  end
                  OP_WRITE: begin
                    st_q <= wel_q ? ST_ADDR : ST_SKIP;
                    rd_mode_q <= 1'b0;
                    addr_second_q <= 1'b0;
                  end
                  default: st_q <= ST_SKIP;
                endcase
              end
            end
            ST_ADDR: begin
              if (!addr_second_q) begin
                addr_hi_q <= rx_byte[HI_W-1:0];
                addr_second_q <= 1'b1;
              end else if (rd_mode_q) begin
                st_q <= ST_RDATA;
                tx_q <= rd_data;
                rd_ptr_q <= addr_full + 1'b1;
                tx_cnt_q <= '0;
                oe_q <= 1'b1;
              end else begin
                st_q <= ST_WDATA;
                w_lo_q <= addr_full[PAGE_W-1:0];
                wr_ok_q <= 1'b0;
              end
            end
            ST_WDATA: begin
              w_lo_q <= w_lo_q + 1'b1;
              wr_ok_q <= 1'b1;
            end
            default: ;
          endcase
        end
        if (sck_fall && (st_q == ST_RDATA || st_q == ST_STAT)) begin
          so_q <= tx_q[7];
          tx_cnt_q <= tx_cnt_q + 1'b1;
          if (tx_cnt_q == 3'd7) begin
            if (st_q == ST_RDATA) begin
              tx_q <= rd_data;
              rd_ptr_q <= rd_ptr_q + 1'b1;
            end else begin
              tx_q <= status;
            end
          end else begin
            tx_q <= {tx_q[6:0], 1'b0};
          end
        end
      end
    end
  end

  assign so_o    = so_q;
  assign so_oe_o = oe_q & cs_act;
endmodule

// File: rtl/spi_ee_checker.sv
module spi_ee_checker
  import spi_ee_pkg::*;
#(
  parameter int PROG_CYCLES = 2000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic csn_i,
  input logic so_oe_o,
  input logic busy,
  input logic wel,
  input st_e  st
);
  logic [31:0] busy_len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   busy_len_q <= '0;
    else if (busy) busy_len_q <= busy_len_q + 1'b1;
    else           busy_len_q <= '0;
  end

  AST_OE_CS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csn_i && $past(csn_i) && $past(csn_i, 2)) |-> !so_oe_o) else $error("oe with cs high"); // R1
  AST_PROG_NEEDS_WEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> wel) else $error("programming without latch"); // R9
  AST_WEL_AUTOCLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> !wel) else $error("latch kept after programming"); // R8
  AST_BUSY_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> busy_len_q == 32'(PROG_CYCLES)) else $error("busy length"); // R4
  AST_NO_READ_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> st != ST_RDATA) else $error("read served while busy"); // R7
endmodule

bind spi_eeprom_slave spi_ee_checker #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .csn_i(csn_i), .so_oe_o(so_oe_o),
  .busy(busy), .wel(wel_q), .st(st_q)
);

// File: tb/spi_eeprom_slave_bench.sv
module spi_eeprom_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;
  localparam int AW = 10;
  localparam int PROG = 1000;

  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, csn = 1'b1, si = 1'b0;
  logic so, so_oe;
  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_q[$], got_q[$];
  string tag_q[$];
  logic [7:0] model [1 << AW];
  logic [7:0] wq[$];

  spi_eeprom_slave #(.ADDR_W(AW), .PAGE_W(5), .PROG_CYCLES(PROG)) u_spi_eeprom_slave (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .csn_i(csn), .si_i(si),
    .so_o(so), .so_oe_o(so_oe));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // monitor: compares received bytes against the expectation queue
  initial forever begin
    logic [7:0] g;
    wait (got_q.size() > 0);
    g = got_q.pop_front();
    if (exp_q.size() == 0) chk(1'b0, "no expectation", g, 8'h00);
    else chk(g === exp_q[0], tag_q[0], g, exp_q[0]);
    if (exp_q.size() > 0) begin void'(exp_q.pop_front()); void'(tag_q.pop_front()); end
  end

  task automatic expect_b(input logic [7:0] v, input string tag);
    exp_q.push_back(v); tag_q.push_back(tag);
  endtask

  task automatic xbit(input logic b, output logic r);
    @(negedge clk); si = b;
    repeat (HALF) @(negedge clk);
    r = so; sck = 1'b1;
    repeat (HALF) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic xbyte(input logic [7:0] d, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) xbit(d[i], r[i]);
  endtask

  task automatic cs_lo();
    @(negedge clk); csn = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_hi();
    repeat (HALF) @(negedge clk);
    csn = 1'b1;
    repeat (4*HALF) @(negedge clk);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] r;
    cs_lo(); xbyte(op, r); cs_hi();
  endtask

  task automatic rdsr(input int n);
    logic [7:0] r;
    cs_lo(); xbyte(8'h05, r);
    for (int i = 0; i < n; i++) begin xbyte(8'h00, r); got_q.push_back(r); end
    cs_hi();
  endtask

  task automatic rdsr_raw(output logic [7:0] r);
    logic [7:0] t;
    cs_lo(); xbyte(8'h05, t); xbyte(8'h00, r); cs_hi();
  endtask

  task automatic wait_ready();
    logic [7:0] r;
    for (int i = 0; i < 100; i++) begin
      rdsr_raw(r);
      if (r[0] == 1'b0) break;
    end
  endtask

  task automatic rd(input logic [15:0] a, input int n, input string tag);
    logic [7:0] r;
    logic [AW-1:0] p;
    p = a[AW-1:0];
    for (int i = 0; i < n; i++) begin expect_b(model[p], tag); p = p + 1'b1; end
    cs_lo(); xbyte(8'h03, r); xbyte(a[15:8], r); xbyte(a[7:0], r);
    for (int i = 0; i < n; i++) begin xbyte(8'h00, r); got_q.push_back(r); end
    cs_hi();
  endtask

  // write the bytes in wq; model follows page wrap when commit is expected
  task automatic wr(input logic [15:0] a, input bit upd);
    logic [7:0] r;
    logic [4:0] lo;
    lo = a[4:0];
    cs_lo(); xbyte(8'h02, r); xbyte(a[15:8], r); xbyte(a[7:0], r);
    foreach (wq[i]) begin
      xbyte(wq[i], r);
      if (upd) model[{a[AW-1:5], lo}] = wq[i];
      lo = lo + 1'b1;
    end
    cs_hi();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 8'h00, 8'h01);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] r;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(so_oe === 1'b0, "R13 oe after reset", {7'b0, so_oe}, 8'h00);
    expect_b(8'h00, "R13 status after reset"); rdsr(1);
    chk(so_oe === 1'b0, "R1 oe with cs high", {7'b0, so_oe}, 8'h00);

    cmd1(8'h06);
    expect_b(8'h02, "R2 latch set"); expect_b(8'h02, "R3 repeated status"); rdsr(2);
    cmd1(8'h04);
    expect_b(8'h00, "R2 latch cleared"); rdsr(1);

    // basic page write and readback
    cmd1(8'h06);
    wq = '{8'h11, 8'h22, 8'h33, 8'h44}; wr(16'h0040, 1'b1);
    expect_b(8'h03, "R4 busy with latch"); rdsr(1);
    // commands during programming
    cs_lo(); xbyte(8'h03, r); xbyte(8'h00, r); xbyte(8'h40, r); xbyte(8'h00, r);
    chk(so_oe === 1'b0, "R7 read ignored while busy", {7'b0, so_oe}, 8'h00);
    cs_hi();
    wait_ready();
    expect_b(8'h00, "R8 latch cleared after programming"); rdsr(1);
    rd(16'h0040, 4, "R4 readback");

    // page wrap over 34 bytes
    cmd1(8'h06);
    wq = {};
    for (int i = 0; i < 34; i++) wq.push_back(8'(8'h80 + i));
    wr(16'h0060, 1'b1); wait_ready();
    rd(16'h0060, 3, "R5 wrap overwrite");
    rd(16'h007E, 2, "R5 page end");
    rd(16'h0040, 2, "R5 neighbour page intact");

    // aborted write mid byte
    cmd1(8'h06);
    cs_lo(); xbyte(8'h02, r); xbyte(8'h00, r); xbyte(8'h40, r); xbyte(8'hEE, r);
    xbit(1'b1, r[0]); xbit(1'b1, r[0]); xbit(1'b1, r[0]);
    cs_hi();
    expect_b(8'h02, "R6 no busy after abort"); rdsr(1);
    rd(16'h0040, 1, "R6 array unchanged");
    cmd1(8'h04);

    // write without latch
    wq = '{8'h00}; wr(16'h0041, 1'b0);
    expect_b(8'h00, "R9 no programming"); rdsr(1);
    rd(16'h0041, 1, "R9 data unchanged");

    // upper address bits ignored
    rd(16'hFC40, 2, "R11 upper bits");

    // read wrap at array end
    cmd1(8'h06); wq = '{8'h99}; wr(16'h03FF, 1'b1); wait_ready();
    cmd1(8'h06); wq = '{8'h5A}; wr(16'h0000, 1'b1); wait_ready();
    rd(16'h03FE, 3, "R10 sequential wrap");

    // unknown opcode and status write
    cs_lo(); xbyte(8'hAB, r); xbyte(8'h05, r); xbyte(8'h00, r);
    chk(so_oe === 1'b0, "R12 unknown opcode silent", {7'b0, so_oe}, 8'h00);
    cs_hi();
    cs_lo(); xbyte(8'h01, r); xbyte(8'hFF, r); cs_hi();
    expect_b(8'h00, "R12 status write ignored"); rdsr(1);

    // SO active during status readout
    cs_lo(); xbyte(8'h05, r);
    repeat (2*HALF) @(negedge clk);
    chk(so_oe === 1'b1, "R1 oe during readout", {7'b0, so_oe}, 8'h01);
    cs_hi();

    wait (got_q.size() == 0);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "scoreboard drained", 8'(exp_q.size()), 8'h00);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule